// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low handshake inputs coming from a modem or data set: clear-to-send, data-set-ready, ring indicate and carrier detect. It resynchronises them to the local clock. It then reports them as one 8-bit status word. The high nibble carries the present asserted level of each line. The low nibble carries sticky change flags, and a read strobe clears those flags. A software read therefore shows both where the lines stand and whether any of them moved since the previous read.

The same block holds a small control register. That register drives four active-low outputs: terminal-ready, request-to-send and two general-purpose outputs. One extra control bit selects a local loopback. In loopback the four outputs are parked at their inactive high level, and the status logic takes its line values from the control bits instead of the input pins. Software can then exercise the change logic with no cable attached. When any change flag is set and the modem-status interrupt enable is high, the block raises an interrupt request.

Top module: `modem_status_unit`

## Requirements
- R1: Status bits 7..4 show the asserted (inverted) level of the resynchronised lines: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring indicate, bit 7 carrier detect. A pin change sampled at one clock edge appears in the status word after the second edge that follows.
- R2: Status bits 0, 1 and 3 set when the clear-to-send, data-set-ready and carrier-detect level changes in either direction. Each stays set until the status word is read.
- R3: Status bit 2 sets only when the ring-indicate pin goes from low (active) to high (inactive). The opposite transition sets nothing.
- R4: A read strobe (`stat_rd_i` high for one cycle) clears all four change flags on the following clock edge.
- R5: Control bits 0..3 drive terminal-ready, request-to-send, output 1 and output 2 in that order. A 1 drives the active-low pin low. All four pins are high while reset is applied and after it.
- R6: When control bit 4 (loopback) is 1, all four control output pins are held high whatever bits 0..3 hold.
- R7: In loopback the status lines are taken from the control bits, not the input pins: clear-to-send from request-to-send (bit 1), data-set-ready from terminal-ready (bit 0), ring indicate from output 1 (bit 2) and carrier detect from output 2 (bit 3). The change flags are computed from these internal values.
- R8: `irq_o` is high exactly when `msi_en_i` is high and at least one change flag is set.
- R9: A line change that reaches the flags in the same cycle as a read strobe is kept as set for the next read, not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring-indicate pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect pin, active low, asynchronous |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 5 | Control write data: bit0 terminal-ready, bit1 request-to-send, bit2 output 1, bit3 output 2, bit4 loopback |
| stat_rd_i | input | 1 | Status read strobe; clears change flags |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| stat_o | output | 8 | Status word: levels in bits 7..4, change flags in bits 3..0 |
| dtr_n_o | output | 1 | Terminal-ready output, active low |
| rts_n_o | output | 1 | Request-to-send output, active low |
| out1_n_o | output | 1 | General output 1, active low |
| out2_n_o | output | 1 | General output 2, active low |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A wrong resynchroniser depth or a wrong level register shows as the status high nibble moving one cycle early or late after a pin edge. The bench model pins that edge down exactly. A wrong flag state shows either as a flag that never sets, as a flag that sets on the leading ring edge, or as a flag that survives a read. Any of these changes both the low nibble and `irq_o` on the very next clock. A wrong loopback mux shows as output pins leaving the high level, or as status bits tracking the pins instead of the control bits, within one or two cycles of the control write.

// File: rtl/msu_pkg.sv
package msu_pkg;
   localparam int LINES   = 4;
   localparam int CTL_W   = 5;
   // status line indices
   localparam int IX_CTS  = 0;
   localparam int IX_DSR  = 1;
   localparam int IX_RI   = 2;
   localparam int IX_DCD  = 3;
   // control bit indices
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OUT1 = 2;
   localparam int CB_OUT2 = 3;
   localparam int CB_LOOP = 4;
   // lines whose flag fires only on deassertion
   localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;

   typedef logic [LINES-1:0] line_vec_t;
   typedef logic [CTL_W-1:0] ctl_vec_t;
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
   parameter int            W       = 4,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d_i,
   output logic [W-1:0]  q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("msu_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("msu_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= RST_VAL;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/msu_edge.sv
module msu_edge #(
   parameter int           W          = 4,
   parameter logic [W-1:0] TRAIL_MASK = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  lvl_i,
   output logic [W-1:0]  lvl_q,
   output logic [W-1:0]  delta_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_i;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (TRAIL_MASK[i]) begin : g_trail
         // asserted -> deasserted only
         assign delta_o[i] = lvl_q[i] & ~lvl_i[i];
      end else begin : g_any
         assign delta_o[i] = lvl_q[i] ^ lvl_i[i];
      end
   end
endmodule

// File: rtl/msu_flags.sv
module msu_flags #(
   parameter int W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_i,
   input  logic [W-1:0]  set_i,
   output logic [W-1:0]  flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (rd_i ? '0 : flag_q) | set_i;
   end

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> flag_q == $past(set_i));                        // R4

   AST_SAME_CYCLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && set_i != '0) |=> flag_q != '0);                 // R9

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> (flag_q & $past(flag_q)) == $past(flag_q));    // R2
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
   import msu_pkg::*;
#(
   parameter int        SYNC_STAGES = 2,
   parameter line_vec_t PIN_RST     = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cts_n_i,
   input  logic             dsr_n_i,
   input  logic             ri_n_i,
   input  logic             dcd_n_i,
   input  logic             ctl_wr_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   input  logic             stat_rd_i,
   input  logic             msi_en_i,
   output logic [7:0]       stat_o,
   output logic             dtr_n_o,
   output logic             rts_n_o,
   output logic             out1_n_o,
   output logic             out2_n_o,
   output logic             irq_o
);
   localparam int STAT_W = 2 * LINES;
   if (STAT_W != 8) begin : g_bad_stat
      $error("modem_status_unit: status word must be 8 bits");
   end

   ctl_vec_t  ctl_q;
   line_vec_t pin_raw, pin_sync, lvl_eff, lvl_q, delta, flag_q, loop_lvl;

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl_q <= '0;
      else if (ctl_wr_i) ctl_q <= ctl_wdata_i;
   end

   // output pins: inactive high in loopback
   assign dtr_n_o  = ctl_q[CB_LOOP] | ~ctl_q[CB_DTR];
   assign rts_n_o  = ctl_q[CB_LOOP] | ~ctl_q[CB_RTS];
   assign out1_n_o = ctl_q[CB_LOOP] | ~ctl_q[CB_OUT1];
   assign out2_n_o = ctl_q[CB_LOOP] | ~ctl_q[CB_OUT2];

   assign pin_raw[IX_CTS] = cts_n_i;
   assign pin_raw[IX_DSR] = dsr_n_i;
   assign pin_raw[IX_RI]  = ri_n_i;
   assign pin_raw[IX_DCD] = dcd_n_i;

   msu_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_raw),
      .q_o   (pin_sync)
   );

   // loopback source: control bits wired back to the status lines
   assign loop_lvl[IX_CTS] = ctl_q[CB_RTS];
   assign loop_lvl[IX_DSR] = ctl_q[CB_DTR];
   assign loop_lvl[IX_RI]  = ctl_q[CB_OUT1];
   assign loop_lvl[IX_DCD] = ctl_q[CB_OUT2];

   assign lvl_eff = ctl_q[CB_LOOP] ? loop_lvl : ~pin_sync;

   msu_edge #(.W(LINES), .TRAIL_MASK(TRAIL_ONLY)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (lvl_eff),
      .lvl_q   (lvl_q),
      .delta_o (delta)
   );

   msu_flags #(.W(LINES)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_i   (stat_rd_i),
      .set_i  (delta),
      .flag_q (flag_q)
   );

   assign stat_o = {lvl_q, flag_q};
   assign irq_o  = msi_en_i & (|flag_q);

   AST_RI_TRAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[IX_RI]) |-> $fell(lvl_q[IX_RI]));           // R3

   for (genvar i = 0; i < LINES; i++) begin : g_chk
      if (!TRAIL_ONLY[i]) begin : g_both
         AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_q[i] != $past(lvl_q[i])) |-> flag_q[i]);      // R2
      end
   end

   AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CB_LOOP] |-> (dtr_n_o && rts_n_o && out1_n_o && out2_n_o)); // R6

   AST_LOOP_CTS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CB_LOOP] |=> lvl_q[IX_CTS] == $past(ctl_q[CB_RTS])); // R7

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (msi_en_i && stat_o[3:0] != 4'b0));           // R8
endmodule

// File: tb/modem_status_unit_bench.sv
module modem_status_unit_bench;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic       ctl_wr = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic       stat_rd = 1'b0;
   logic       msi_en = 1'b0;
   logic [7:0] stat;
   logic       dtr_n, rts_n, out1_n, out2_n, irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit running = 1'b0;

   modem_status_unit u_modem_status_unit (
      .clk(clk), .rst_n(rst_n),
      .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .dcd_n_i(dcd_n),
      .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
      .stat_rd_i(stat_rd), .msi_en_i(msi_en),
      .stat_o(stat), .dtr_n_o(dtr_n), .rts_n_o(rts_n),
      .out1_n_o(out1_n), .out2_n_o(out2_n), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: pin history, levels, flags, control
   logic [3:0] m_h1 = 4'hF, m_h2 = 4'hF, m_lvl = '0, m_flg = '0;
   logic [4:0] m_ctl = '0;

   always @(posedge clk) begin
      logic [3:0] eff, dl;
      if (!rst_n) begin
         m_h1 = 4'hF; m_h2 = 4'hF; m_lvl = '0; m_flg = '0; m_ctl = '0;
      end else begin
         if (m_ctl[4]) eff = {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
         else          eff = ~m_h2;
         dl    = eff ^ m_lvl;
         dl[2] = m_lvl[2] & ~eff[2];
         m_flg = (stat_rd ? 4'b0 : m_flg) | dl;
         m_lvl = eff;
         if (ctl_wr) m_ctl = ctl_wdata;
         m_h2 = m_h1;
         m_h1 = {dcd_n, ri_n, dsr_n, cts_n};
      end
   end

   // compare every cycle, 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (running) begin
         chk("R1 levels", {4'b0, stat[7:4]}, {4'b0, m_lvl});
         chk("R2 change flags", {5'b0, stat[3], stat[1:0]}, {5'b0, m_flg[3], m_flg[1:0]});
         chk("R3 ring flag", {7'b0, stat[2]}, {7'b0, m_flg[2]});
         chk(m_ctl[4] ? "R6 loop pins" : "R5 pins",
             {4'b0, out2_n, out1_n, rts_n, dtr_n},
             {4'b0, (m_ctl[4] ? 4'hF : ~m_ctl[3:0])});
         chk("R8 irq", {7'b0, irq}, {7'b0, msi_en & (|m_flg)});
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_rd();
      stat_rd = 1'b1; step(1); stat_rd = 1'b0;
   endtask

   task automatic wr_ctl(input logic [4:0] v);
      ctl_wdata = v; ctl_wr = 1'b1; step(1); ctl_wr = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000.0);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] lf;
      step(1);
      running = 1'b1;
      step(2);
      // R5 reset state
      chk("R5 reset pins", {4'b0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
      chk("R4 reset status", stat, 8'h00);
      rst_n = 1'b1;
      step(4);

      cts_n = 1'b0; step(4);
      chk("R2 cts flag", {7'b0, stat[0]}, 8'h01);
      chk("R1 cts level", {7'b0, stat[4]}, 8'h01);
      pulse_rd();
      chk("R4 read clears", {4'b0, stat[3:0]}, 8'h00);

      cts_n = 1'b1; dsr_n = 1'b0; dcd_n = 1'b0; step(4);
      chk("R2 three flags", {4'b0, stat[3:0]}, 8'h0B);
      pulse_rd();

      ri_n = 1'b0; step(4);
      chk("R3 leading ring ignored", {7'b0, stat[2]}, 8'h00);
      chk("R1 ring level", {7'b0, stat[6]}, 8'h01);
      ri_n = 1'b1; step(4);
      chk("R3 trailing ring flagged", {7'b0, stat[2]}, 8'h01);
      pulse_rd();

      // R9 change arriving with the read strobe
      dcd_n = 1'b1; step(2);
      stat_rd = 1'b1; step(1); stat_rd = 1'b0;
      chk("R9 kept across read", {7'b0, stat[3]}, 8'h01);
      pulse_rd();
      chk("R4 cleared after second read", {4'b0, stat[3:0]}, 8'h00);

      wr_ctl(5'b00101);
      chk("R5 pins", {4'b0, out2_n, out1_n, rts_n, dtr_n}, 8'h0A);

      msi_en = 1'b1; dsr_n = 1'b1; step(4);
      chk("R8 irq set", {7'b0, irq}, 8'h01);
      pulse_rd();
      chk("R8 irq cleared", {7'b0, irq}, 8'h00);

      wr_ctl(5'b10010); step(2);
      chk("R6 loop pins idle", {4'b0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
      chk("R7 cts follows rts", {6'b0, stat[5:4]}, 8'h01);
      cts_n = 1'b0; dsr_n = 1'b0; step(4);
      chk("R7 pins ignored", {4'b0, stat[7:4]}, 8'h01);
      pulse_rd();
      wr_ctl(5'b10100); step(2);
      pulse_rd();
      wr_ctl(5'b10000); step(2);
      chk("R7 ring from out1", {7'b0, stat[2]}, 8'h01);
      wr_ctl(5'b00000); step(4);
      pulse_rd();

      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (lf[3:0] == 4'h0) cts_n = ~cts_n;
         if (lf[7:4] == 4'h1) dsr_n = ~dsr_n;
         if (lf[11:8] == 4'h2) ri_n = ~ri_n;
         if (lf[15:12] == 4'h3) dcd_n = ~dcd_n;
         stat_rd = (lf[6:4] == 3'd5);
         msi_en  = lf[9];
         ctl_wr  = (lf[14:11] == 4'h7);
         ctl_wdata = lf[4:0];
         step(1);
      end
      stat_rd = 1'b0; ctl_wr = 1'b0;
      step(4);
      running = 1'b0;
      finish_run();
   end
endmodule